// File: doc/BRIEF.md
# Fetch-Stage Direction and Target Predictor

This block guesses, every cycle, where instruction fetch should go next. It takes the current fetch address and returns two things: a taken/not-taken guess and the address to fetch next. The direction guess comes from a table of two-bit saturating counters. The target comes from a small tagged cache of branch destinations. Both structures are indexed by low word-address bits of the PC. When a taken guess meets a valid, tag-matching target entry, fetch is redirected with no bubble. In every other case fetch simply moves on by one word.

When a branch resolves further down the pipeline, the block receives four things: the branch address, the real outcome, the real destination, and the guess that was made for that branch. In the same cycle it raises a flush request if the guess was wrong. On the next clock edge it trains its counter and, for taken branches, its target entry. Each counter needs two wrong guesses in a row before its direction flips. This keeps a loop-closing branch from being mispredicted both on loop exit and again on loop re-entry. The table sizes are parameters.

Top module: `fetch_predictor`

## Requirements
- R1: After reset, every counter holds 01 and every target entry is invalid. Any lookup then gives predict_taken = 0 and predict_next_pc = fetch_pc + 4.
- R2: Counters use this encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A taken resolve moves the counter one step up and a not-taken resolve moves it one step down. The counter saturates at 11 and at 00. predict_taken is counter bit 1.
- R3: A counter in state 11 needs two consecutive not-taken resolves before predict_taken goes to 0. After only one, the prediction stays taken.
- R4: predict_next_pc equals the stored target when predict_taken is 1 and the target entry hits. Otherwise it equals fetch_pc + 4.
- R5: A target entry hits only when its valid bit is set and its stored tag matches fetch_pc[31:2+log2(target depth)]. A PC that shares the index but carries a different tag misses.
- R6: The counter index is fetch_pc[log2(depth)+1:2] and the target index is fetch_pc[log2(target depth)+1:2]. PC bits [1:0] have no effect on a lookup.
- R7: A resolve and a lookup to the same entry in the same cycle do not bypass. The lookup returns the old entry, and the new value appears from the next cycle on.
- R8: flush_req is 1 in the resolve cycle if either of two conditions holds: res_taken differs from res_was_taken, or the branch was taken and res_target differs from res_was_target. Otherwise flush_req is 0, and it is always 0 when res_valid is 0.
- R9: A taken resolve writes the entry as valid, with the branch's tag and res_target. A not-taken resolve leaves the target entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| predict_taken | output | 1 | Direction guess for fetch_pc |
| predict_next_pc | output | 32 | Address to fetch next |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Real direction of the branch |
| res_target | input | 32 | Real destination of the branch |
| res_was_taken | input | 1 | Direction that was guessed for it |
| res_was_target | input | 32 | Next address that was guessed for it |
| flush_req | output | 1 | Guess was wrong, pipeline must restart |

## Verification
The counters are driven with three run shapes: a taken run up to saturation, an alternating run that checks a single opposite outcome does not flip a strong counter, and a not-taken run past 00 that shows saturation at the low end. The target path is tried with three lookups: a PC that hits, a PC with the same index but a different tag, and a PC that differs only in its byte-offset bits. Together these separate a correct tag compare from an index-only match. A resolve and a lookup aimed at one entry in the same cycle show that there is no write-through. The flush output is driven with a direction mismatch, a target-only mismatch, a target difference on a not-taken branch, and an invalid resolve.

// File: rtl/fp_pkg.sv
// Shared types and helpers for the fetch predictor.
package fp_pkg;

    // Two-bit hysteresis counter states, ordered so bit 1 is the direction.
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_t;

    // Saturating one-step move of a counter toward the resolved direction.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_ST) ? CTR_ST : ctr_t'(cur + 2'd1);
        end else begin
            nxt = (cur == CTR_SNT) ? CTR_SNT : ctr_t'(cur - 2'd1);
        end
        return nxt;
    endfunction

endpackage

// File: rtl/fp_dir_table.sv
// Direction table: DEPTH two-bit saturating counters, indexed by PC word bits.
// Assumes DEPTH is a power of two. Reads are combinational and writes land
// on the clock edge, so a same-cycle write is not visible to the read.
module fp_dir_table
    import fp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int DEPTH = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rd_pc,
    output logic            rd_taken,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic            wr_taken
);
    localparam int IW = $clog2(DEPTH);

    ctr_t           ctr_q [DEPTH];
    logic [IW-1:0]  rd_idx;
    logic [IW-1:0]  wr_idx;

    // Index extraction: word-aligned, so bits [1:0] are skipped.
    assign rd_idx = rd_pc[IW+1:2];
    assign wr_idx = wr_pc[IW+1:2];

    // Lookup reads the stored counter direction bit.
    assign rd_taken = ctr_q[rd_idx][1];

    // Counter storage: reset to weak not-taken, train on each resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_WNT;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    // R2: strong taken stays at strong taken on another taken outcome
    p_sat_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_ST)
        |=> ctr_q[$past(wr_idx)] == CTR_ST);

    // R2: strong not-taken stays at strong not-taken on another not-taken
    p_sat_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_SNT)
        |=> ctr_q[$past(wr_idx)] == CTR_SNT);

    // R3: one not-taken from strong taken only weakens, direction unchanged
    p_hysteresis_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_ST)
        |=> ctr_q[$past(wr_idx)] == CTR_WT);

endmodule

// File: rtl/fp_target_cache.sv
// Tagged target cache: DEPTH entries of {valid, tag, target}, direct mapped
// by PC word bits. Assumes DEPTH is a power of two. Taken resolves fill an
// entry; not-taken resolves leave it alone. No read-after-write bypass.
module fp_target_cache #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] rd_pc,
    output logic            rd_hit,
    output logic [XLEN-1:0] rd_target,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_pc,
    input  logic            wr_taken,
    input  logic [XLEN-1:0] wr_target
);
    localparam int IW = $clog2(DEPTH);
    localparam int TW = XLEN - IW - 2;

    logic            valid_q  [DEPTH];
    logic [TW-1:0]   tag_q    [DEPTH];
    logic [XLEN-1:0] target_q [DEPTH];

    logic [IW-1:0]   rd_idx;
    logic [IW-1:0]   wr_idx;
    logic [TW-1:0]   rd_tag;
    logic [TW-1:0]   wr_tag;

    // Split PCs into index and tag fields.
    assign rd_idx = rd_pc[IW+1:2];
    assign wr_idx = wr_pc[IW+1:2];
    assign rd_tag = rd_pc[XLEN-1:IW+2];
    assign wr_tag = wr_pc[XLEN-1:IW+2];

    // Hit needs a live entry whose tag matches the fetch address.
    assign rd_hit    = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
    assign rd_target = target_q[rd_idx];

    // Valid bits: cleared on reset, set by taken resolves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                valid_q[i] <= 1'b0;
            end
        end else if (wr_en && wr_taken) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target payload: written alongside the valid bit, no reset.
    always_ff @(posedge clk) begin
        if (wr_en && wr_taken) begin
            tag_q[wr_idx]    <= wr_tag;
            target_q[wr_idx] <= wr_target;
        end
    end

    // R9: a taken resolve leaves a valid entry with the resolved target
    p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken)
        |=> valid_q[$past(wr_idx)] && target_q[$past(wr_idx)] == $past(wr_target));

    // R9: a not-taken resolve does not disturb the entry it maps to
    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken)
        |=> valid_q[$past(wr_idx)] == $past(valid_q[wr_idx])
            && target_q[$past(wr_idx)] == $past(target_q[wr_idx]));

endmodule

// File: rtl/fp_resolve.sv
// Resolve checker: compares the guess carried with a branch against its real
// outcome and raises a flush request in the same cycle. Purely combinational.
module fp_resolve #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            taken,
    input  logic [XLEN-1:0] target,
    input  logic            was_taken,
    input  logic [XLEN-1:0] was_target,
    output logic            flush
);
    logic dir_wrong;
    logic tgt_wrong;

    // Direction and target mismatch terms.
    always_comb begin
        dir_wrong = (taken != was_taken);
        tgt_wrong = taken && (target != was_target);
        flush     = valid && (dir_wrong || tgt_wrong);
    end

    // R8: no flush request without a resolving branch
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> !flush);

    // R8: a correct direction on a not-taken branch never flushes
    p_nt_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !taken && !was_taken) |-> !flush);

endmodule

// File: rtl/fetch_predictor.sv
// Fetch predictor top: direction table plus tagged target cache, feeding a
// next-PC select, and a resolve checker that requests a pipeline flush.
// Assumes word-aligned instructions and one resolve per cycle at most.
module fetch_predictor #(
    parameter int XLEN        = 32,
    parameter int DIR_DEPTH   = 64,
    parameter int TGT_DEPTH   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] fetch_pc,
    output logic            predict_taken,
    output logic [XLEN-1:0] predict_next_pc,
    input  logic            res_valid,
    input  logic [XLEN-1:0] res_pc,
    input  logic            res_taken,
    input  logic [XLEN-1:0] res_target,
    input  logic            res_was_taken,
    input  logic [XLEN-1:0] res_was_target,
    output logic            flush_req
);
    localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);

    logic            dir_taken;
    logic            tgt_hit;
    logic [XLEN-1:0] tgt_addr;

    fp_dir_table #(.XLEN(XLEN), .DEPTH(DIR_DEPTH)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_pc    (fetch_pc),
        .rd_taken (dir_taken),
        .wr_en    (res_valid),
        .wr_pc    (res_pc),
        .wr_taken (res_taken)
    );

    fp_target_cache #(.XLEN(XLEN), .DEPTH(TGT_DEPTH)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_pc     (fetch_pc),
        .rd_hit    (tgt_hit),
        .rd_target (tgt_addr),
        .wr_en     (res_valid),
        .wr_pc     (res_pc),
        .wr_taken  (res_taken),
        .wr_target (res_target)
    );

    fp_resolve #(.XLEN(XLEN)) u_res (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (res_valid),
        .taken      (res_taken),
        .target     (res_target),
        .was_taken  (res_was_taken),
        .was_target (res_was_target),
        .flush      (flush_req)
    );

    // Next-PC select: redirect only on taken guess with a cached target.
    always_comb begin
        predict_taken   = dir_taken;
        predict_next_pc = (dir_taken && tgt_hit) ? tgt_addr : fetch_pc + WORD_STEP;
    end

    // R1: first cycle out of reset predicts not-taken
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !predict_taken && predict_next_pc == fetch_pc + WORD_STEP);

    // R4: a not-taken guess always falls through to the next word
    p_fallthrough_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !predict_taken |-> predict_next_pc == fetch_pc + WORD_STEP);

endmodule

// File: tb/fetch_predictor_bench.sv
`timescale 1ns/1ps
module fetch_predictor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = 32'h0;
    logic        predict_taken;
    logic [31:0] predict_next_pc;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = 32'h0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = 32'h0;
    logic        res_was_taken = 1'b0;
    logic [31:0] res_was_target = 32'h0;
    logic        flush_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fetch_predictor u_fetch_predictor (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .predict_taken  (predict_taken),
        .predict_next_pc(predict_next_pc),
        .res_valid      (res_valid),
        .res_pc         (res_pc),
        .res_taken      (res_taken),
        .res_target     (res_target),
        .res_was_taken  (res_was_taken),
        .res_was_target (res_was_target),
        .flush_req      (flush_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply a lookup and compare both prediction outputs.
    task automatic look(input logic [31:0] pc, input logic exp_t,
                        input logic [31:0] exp_n, input string req);
        @(negedge clk);
        fetch_pc = pc;
        #1;
        check({req, " taken"}, {31'd0, predict_taken}, {31'd0, exp_t});
        check({req, " next"}, predict_next_pc, exp_n);
    endtask

    // Present one resolve for a cycle and compare the flush request.
    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tg,
                           input logic wtk, input logic [31:0] wtg,
                           input logic exp_f, input string req);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tg;
        res_was_taken = wtk; res_was_target = wtg;
        #1;
        check({req, " flush"}, {31'd0, flush_req}, {31'd0, exp_f});
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // R1: reset state gives not-taken and fall-through everywhere.
    task automatic t_reset();
        look(32'h0000_0100, 1'b0, 32'h0000_0104, "R1 reset");
        look(32'h0000_1000, 1'b0, 32'h0000_1004, "R1 reset");
    endtask

    // R2 R3 R4 R8 R9: train A up, hysteresis down, target retention.
    task automatic t_train_a();
        resolve(32'h1000, 1'b1, 32'h2000, 1'b0, 32'h1004, 1'b1, "R8 dir miss");
        look(32'h1000, 1'b1, 32'h2000, "R2 R4 weak taken hit");
        resolve(32'h1000, 1'b1, 32'h2000, 1'b1, 32'h2000, 1'b0, "R8 correct");
        resolve(32'h1000, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, "R8 nt miss");
        look(32'h1000, 1'b1, 32'h2000, "R3 one miss keeps taken");
        resolve(32'h1000, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, "R8 nt miss 2");
        look(32'h1000, 1'b0, 32'h1004, "R3 two misses flip");
        resolve(32'h1000, 1'b1, 32'h2000, 1'b0, 32'h1004, 1'b1, "R8 dir miss 2");
        look(32'h1000, 1'b1, 32'h2000, "R9 target kept through nt");
    endtask

    // R2: low saturation needs two taken steps out of 00.
    task automatic t_sat_low();
        resolve(32'h3010, 1'b0, 32'h0, 1'b0, 32'h3014, 1'b0, "R8 nt ok");
        resolve(32'h3010, 1'b0, 32'h0, 1'b0, 32'h3014, 1'b0, "R8 nt ok 2");
        resolve(32'h3010, 1'b1, 32'h3800, 1'b0, 32'h3014, 1'b1, "R8 miss");
        look(32'h3010, 1'b0, 32'h3014, "R2 saturated low");
        resolve(32'h3010, 1'b1, 32'h3800, 1'b0, 32'h3014, 1'b1, "R8 miss 2");
        look(32'h3010, 1'b1, 32'h3800, "R2 rises to taken");
    endtask

    // R5 R6: tag mismatch misses; offset bits ignored.
    task automatic t_alias();
        look(32'h5000, 1'b1, 32'h5004, "R5 tag miss");
        look(32'h1001, 1'b1, 32'h2000, "R6 low bits ignored");
        look(32'h1003, 1'b1, 32'h2000, "R6 low bits ignored 2");
    endtask

    // R7: same-cycle resolve is not seen by the lookup.
    task automatic t_no_bypass();
        @(negedge clk);
        fetch_pc = 32'h4020;
        res_valid = 1'b1; res_pc = 32'h4020; res_taken = 1'b1;
        res_target = 32'h4400; res_was_taken = 1'b0; res_was_target = 32'h4024;
        #1;
        check("R7 old taken", {31'd0, predict_taken}, 32'd0);
        check("R7 old next", predict_next_pc, 32'h4024);
        @(negedge clk);
        res_valid = 1'b0;
        #1;
        check("R7 new taken", {31'd0, predict_taken}, 32'd1);
        check("R7 new next", predict_next_pc, 32'h4400);
    endtask

    // R8: target-only mismatch, nt target difference, idle.
    task automatic t_flush();
        resolve(32'h1000, 1'b1, 32'h2000, 1'b1, 32'h2100, 1'b1, "R8 target miss");
        resolve(32'h1000, 1'b0, 32'h2000, 1'b0, 32'h2100, 1'b0, "R8 nt target ignored");
        @(negedge clk);
        res_valid = 1'b0; res_taken = 1'b1; res_was_taken = 1'b0;
        #1;
        check("R8 idle", {31'd0, flush_req}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_train_a();
        t_sat_low();
        t_alias();
        t_no_bypass();
        t_flush();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule